// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

This block is one channel that sits beside a free-running 16-bit timer and serves as a capture unit, a compare unit or a pulse-width modulator. A 4-bit mode code in the control register selects the function. In capture mode, chosen edges on an input pin copy the timer value into the 16-bit data register. In compare mode, the channel watches for the timer to equal the data register and then acts on the output pin, raises a sticky event flag, or pulses a timer-reset and a conversion-start line. In PWM mode it drives a waveform whose 10-bit duty is split between the low data byte and a 2-bit fraction field.

Software reaches the channel through a byte-wide write/read port with four addresses. The timer, the converter and any pin routing are outside this block.

Top module: `ccp_channel`

## Requirements
- R1: Mode codes 0000, 0001 and 0011 turn the channel off. The pin is driven low, the compare latch, the edge prescaler and the PWM shadow duty are cleared, and a compare match changes neither the pin nor the flag.
- R2: Address 0 holds the control byte, with the mode in bits [3:0] and the duty fraction in bits [5:4]. Address 1 is the low data byte and address 2 the high data byte. A write to address 3 clears the flag. A read of address 3 returns the flag in bit 0, and reads of the other addresses return the stored values.
- R3: Mode 0101 captures on each rising edge of the pin and mode 0100 on each falling edge; the other edge is ignored. A capture copies the timer into the data register and sets the flag 3 cycles after the pin changes.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th rising edge. The edges in between leave the data register and the flag untouched.
- R5: Any write that changes the mode code restarts the edge prescaler count from zero.
- R6: Mode 1000 drives the pin high and mode 1001 drives it low on a compare match. Both set the flag one cycle after the timer equals the data register.
- R7: Mode 0010 inverts the pin on a compare match. An action happens only on the first cycle of an equality, so a timer held at the match value acts once.
- R8: Mode 1010 sets only the flag on a match. Mode 1011 sets the flag and pulses the timer-reset and conversion-start outputs for exactly one cycle. In both modes the pin is left unchanged.
- R9: The flag stays set until address 3 is written. A flag set in the same cycle as a clear wins.
- R10: Mode codes 11xx select PWM with duty = {data low byte, duty fraction}. The pin is high while the low 10 timer bits are below the active duty, one cycle after the timer value.
- R11: The active PWM duty is loaded from the registers only when the low 10 timer bits equal 0. A duty of 0 keeps the pin low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tmr_cnt | input | 16 | Timer count |
| pin_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Channel output pin |
| irq_flag | output | 1 | Sticky event flag |
| tmr_rst | output | 1 | One-cycle timer-reset pulse |
| adc_start | output | 1 | One-cycle conversion-start pulse |

## Verification
Register writes become visible at the first falling edge after the write strobe. Compare actions, PWM levels and the trigger pulses are due one clock after the timer value is applied. A capture is due three clocks after the pin changes, because of two synchroniser flops and one history flop. The bench queues each expectation with the cycle it falls due and samples it at the falling edge of exactly that cycle. Between a stimulus and its due cycle the timer is held steady, so the captured value is unambiguous.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [1:0] {GRP_OFF, GRP_CAP, GRP_CMP, GRP_PWM} grp_e;
  typedef enum logic [1:0] {ACT_TOGGLE, ACT_SET, ACT_CLR, ACT_NONE} act_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DLO  = 2'd1;
  localparam logic [1:0] ADDR_DHI  = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  function automatic grp_e mode_group(input logic [3:0] m);
    grp_e g;
    casez (m)
      4'b0010: g = GRP_CMP;
      4'b01??: g = GRP_CAP;
      4'b10??: g = GRP_CMP;
      4'b11??: g = GRP_PWM;
      default: g = GRP_OFF;
    endcase
    return g;
  endfunction

  function automatic act_e cmp_action(input logic [3:0] m);
    act_e a;
    case (m)
      4'b0010: a = ACT_TOGGLE;
      4'b1000: a = ACT_SET;
      4'b1001: a = ACT_CLR;
      default: a = ACT_NONE;
    endcase
    return a;
  endfunction

  function automatic logic [4:0] cap_div(input logic [3:0] m);
    logic [4:0] d;
    case (m)
      4'b0110: d = 5'd4;
      4'b0111: d = 5'd16;
      default: d = 5'd1;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ccp_capture.sv
module ccp_capture #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_DIV     = 16,
  localparam int PRE_W      = $clog2(MAX_DIV)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pin_in,
  input  logic           enable,
  input  logic           falling,
  input  logic [PRE_W:0] div,
  input  logic           clr,
  output logic           cap_fire
);

  logic [SYNC_STAGES:0] sh_q, sh_d;
  logic [PRE_W-1:0]     pre_q, pre_d;
  logic                 lvl, prev, edge_hit, last;

  always_comb begin
    sh_d     = {sh_q[SYNC_STAGES-1:0], pin_in};
    lvl      = sh_q[SYNC_STAGES-1];
    prev     = sh_q[SYNC_STAGES];
    edge_hit = enable && (falling ? (!lvl && prev) : (lvl && !prev));
    last     = ({1'b0, pre_q} == (div - 1'b1));
    cap_fire = edge_hit && last && !clr;
    pre_d    = pre_q;
    if (clr)           pre_d = '0;
    else if (edge_hit) pre_d = last ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pre_q <= '0;
    end else begin
      sh_q  <= sh_d;
      pre_q <= pre_d;
    end
  end

  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> ({1'b0, pre_q} < div));

  assert_clr_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));

endmodule

// File: rtl/ccp_compare.sv
module ccp_compare
  import ccp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             off,
  input  act_e             act,
  input  logic             special,
  input  logic [TMR_W-1:0] tmr,
  input  logic [TMR_W-1:0] ref_val,
  output logic             evt,
  output logic             pin_q,
  output logic             trig_q
);

  logic match, match_q, pin_d, trig_d;

  always_comb begin
    match  = (tmr == ref_val);
    evt    = enable && match && !match_q;
    trig_d = evt && special;
    pin_d  = pin_q;
    if (off) pin_d = 1'b0;
    else if (evt) begin
      case (act)
        ACT_TOGGLE: pin_d = !pin_q;
        ACT_SET:    pin_d = 1'b1;
        ACT_CLR:    pin_d = 1'b0;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      pin_q   <= 1'b0;
      trig_q  <= 1'b0;
    end else begin
      match_q <= match;
      pin_q   <= pin_d;
      trig_q  <= trig_d;
    end
  end

  assert_off_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !pin_q);

  assert_set_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && act == ACT_SET) |=> pin_q);

  assert_single_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);

  assert_trig_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trig_q |=> !trig_q);

endmodule

// File: rtl/ccp_pwm.sv
module ccp_pwm #(
  parameter int PWM_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PWM_W-1:0] cnt,
  input  logic [PWM_W-1:0] duty,
  output logic             pwm_q
);

  logic [PWM_W-1:0] shadow_q, shadow_d, duty_eff;
  logic             rollover, pwm_d;

  always_comb begin
    rollover = (cnt == '0);
    duty_eff = rollover ? duty : shadow_q;
    shadow_d = !enable ? '0 : duty_eff;
    pwm_d    = enable && (cnt < duty_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pwm_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      pwm_q    <= pwm_d;
    end
  end

  assert_zero_duty_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow_q == '0 && cnt != '0) |=> !pwm_q);

  assert_shadow_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt != '0) |=> (shadow_q == $past(shadow_q)));

endmodule

// File: rtl/ccp_channel.sv
module ccp_channel
  import ccp_pkg::*;
#(
  parameter int TMR_W       = 16,
  parameter int DC_W        = 2,
  parameter int SYNC_STAGES = 2,
  localparam int PWM_W      = 8 + DC_W,
  localparam int PRE_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       rd_addr,
  output logic [7:0]       rd_data,
  input  logic [TMR_W-1:0] tmr_cnt,
  input  logic             pin_in,
  output logic             pin_out,
  output logic             irq_flag,
  output logic             tmr_rst,
  output logic             adc_start
);

  logic [1:0]       rsync_q;
  logic             rst_ni;
  logic [3:0]       mode_q, mode_d;
  logic [DC_W-1:0]  dc_q, dc_d;
  logic [TMR_W-1:0] data_q, data_d;
  logic             flag_q, flag_d;
  grp_e             grp;
  act_e             act;
  logic             is_cap, is_cmp, is_pwm, is_off;
  logic             ctrl_wr, mode_chg, flag_clr, cap_clr;
  logic             cap_fire, cmp_evt, cmp_pin, trig_q, pwm_pin;
  logic [PRE_W:0]   div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  always_comb begin
    grp      = mode_group(mode_q);
    act      = cmp_action(mode_q);
    is_cap   = (grp == GRP_CAP);
    is_cmp   = (grp == GRP_CMP);
    is_pwm   = (grp == GRP_PWM);
    is_off   = (grp == GRP_OFF);
    div      = cap_div(mode_q);
    ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    flag_clr = wr_en && (wr_addr == ADDR_FLAG);
    mode_chg = ctrl_wr && (wr_data[3:0] != mode_q);
    cap_clr  = mode_chg || !is_cap;

    mode_d = mode_q;
    dc_d   = dc_q;
    if (ctrl_wr) begin
      mode_d = wr_data[3:0];
      dc_d   = wr_data[4 +: DC_W];
    end

    data_d = data_q;
    if (cap_fire) data_d = tmr_cnt;
    else if (wr_en && wr_addr == ADDR_DLO) data_d[7:0] = wr_data;
    else if (wr_en && wr_addr == ADDR_DHI) data_d[TMR_W-1:8] = wr_data;

    flag_d = flag_q;
    if (cap_fire || cmp_evt) flag_d = 1'b1;
    else if (flag_clr)       flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      dc_q   <= '0;
      data_q <= '0;
      flag_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      dc_q   <= dc_d;
      data_q <= data_d;
      flag_q <= flag_d;
    end
  end

  ccp_capture #(.SYNC_STAGES(SYNC_STAGES), .MAX_DIV(16)) u_cap (
    .clk(clk), .rst_n(rst_ni), .pin_in(pin_in), .enable(is_cap),
    .falling(mode_q[1:0] == 2'b00), .div(div), .clr(cap_clr),
    .cap_fire(cap_fire)
  );

  ccp_compare #(.TMR_W(TMR_W)) u_cmp (
    .clk(clk), .rst_n(rst_ni), .enable(is_cmp), .off(is_off), .act(act),
    .special(mode_q == 4'b1011), .tmr(tmr_cnt), .ref_val(data_q),
    .evt(cmp_evt), .pin_q(cmp_pin), .trig_q(trig_q)
  );

  ccp_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk(clk), .rst_n(rst_ni), .enable(is_pwm), .cnt(tmr_cnt[PWM_W-1:0]),
    .duty({data_q[7:0], dc_q}), .pwm_q(pwm_pin)
  );

  always_comb begin
    pin_out   = is_cmp ? cmp_pin : (is_pwm ? pwm_pin : 1'b0);
    irq_flag  = flag_q;
    tmr_rst   = trig_q;
    adc_start = trig_q;
    case (rd_addr)
      ADDR_CTRL: rd_data = {{(4 - DC_W){1'b0}}, dc_q, mode_q};
      ADDR_DLO:  rd_data = data_q[7:0];
      ADDR_DHI:  rd_data = data_q[TMR_W-1:8];
      default:   rd_data = {7'b0, flag_q};
    endcase
  end

  assert_capture_copy_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    cap_fire |=> (data_q == $past(tmr_cnt)) && irq_flag);

  assert_trig_flag_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    tmr_rst |-> irq_flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: tb/tb_ccp_channel.sv
`timescale 1ns/1ps
module tb_ccp_channel;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [1:0]  rd_addr;
  logic [7:0]  rd_data;
  logic [15:0] tmr_cnt;
  logic        pin_in;
  logic        pin_out, irq_flag, tmr_rst, adc_start;

  always #2.5 clk = ~clk;

  ccp_channel dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tmr_cnt(tmr_cnt), .pin_in(pin_in), .pin_out(pin_out),
    .irq_flag(irq_flag), .tmr_rst(tmr_rst), .adc_start(adc_start)
  );

  // sel: 0 pin, 1 flag, 2 timer reset, 3 conversion start, 4 data word, 5 control byte
  typedef struct {
    int          due;
    int          sel;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int dly, input int sel, input logic [15:0] exp,
                           input string req);
    item_t it;
    int    idx;
    it.due = cyc + dly; it.sel = sel; it.exp = exp; it.req = req;
    idx = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].due > it.due) begin idx = i; break; end
    end
    q.insert(idx, it);
  endtask

  task automatic observe(input int sel, output logic [15:0] v);
    case (sel)
      0: v = {15'b0, pin_out};
      1: v = {15'b0, irq_flag};
      2: v = {15'b0, tmr_rst};
      3: v = {15'b0, adc_start};
      4: begin
        rd_addr = 2'd1; #0.1; v[7:0]  = rd_data;
        rd_addr = 2'd2; #0.1; v[15:8] = rd_data;
      end
      default: begin rd_addr = 2'd0; #0.1; v = {8'b0, rd_data}; end
    endcase
  endtask

  // monitor: pops due items and compares
  initial begin
    item_t       it;
    logic [15:0] got;
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        it = q.pop_front();
        observe(it.sel, got);
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
      end
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] v);
    pin_in = 1'b0;
    step(2);
    tmr_cnt = v; pin_in = 1'b1;
    step(4);
  endtask

  task automatic match_at(input logic [15:0] v);
    tmr_cnt = v - 16'd1;
    step(2);
    tmr_cnt = v;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; tmr_cnt = '0; pin_in = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(4);
    // reset state
    expect_at(0, 0, 0, "R1"); expect_at(0, 1, 0, "R9");
    expect_at(0, 2, 0, "R8"); expect_at(0, 5, 0, "R2");
    step(2);

    // rising capture
    wr(2'd0, 8'h05);
    tmr_cnt = 16'h1234; pin_in = 1'b1;
    expect_at(2, 1, 0, "R3");
    expect_at(3, 4, 16'h1234, "R3"); expect_at(3, 1, 1, "R3");
    step(6);
    expect_at(0, 1, 1, "R9");
    wr(2'd3, 8'h00);
    expect_at(0, 1, 0, "R9");
    // falling capture
    wr(2'd0, 8'h04);
    tmr_cnt = 16'h0BEE; pin_in = 1'b0;
    expect_at(3, 4, 16'h0BEE, "R3");
    step(5);
    wr(2'd3, 8'h00);
    tmr_cnt = 16'h5555; pin_in = 1'b1;
    expect_at(3, 4, 16'h0BEE, "R3"); expect_at(4, 1, 0, "R3");
    step(6);

    // every 4th rising edge
    wr(2'd0, 8'h06);
    pulse(16'h0010); pulse(16'h0011); pulse(16'h0012);
    expect_at(0, 4, 16'h0BEE, "R4"); expect_at(0, 1, 0, "R4");
    pulse(16'h0013);
    expect_at(0, 4, 16'h0013, "R4"); expect_at(0, 1, 1, "R4");
    step(1);
    wr(2'd3, 8'h00);

    // mode change restarts prescaler
    wr(2'd0, 8'h07);
    pulse(16'h0020); pulse(16'h0021);
    wr(2'd0, 8'h06);
    pulse(16'h0030); pulse(16'h0031); pulse(16'h0032);
    expect_at(0, 4, 16'h0013, "R5"); expect_at(0, 1, 0, "R5");
    pulse(16'h0033);
    expect_at(0, 4, 16'h0033, "R5");
    step(1);
    wr(2'd3, 8'h00);

    // every 16th rising edge
    wr(2'd0, 8'h07);
    for (int i = 0; i < 15; i++) pulse(16'h0040 + 16'(i));
    expect_at(0, 4, 16'h0033, "R4"); expect_at(0, 1, 0, "R4");
    pulse(16'h004F);
    expect_at(0, 4, 16'h004F, "R4"); expect_at(0, 1, 1, "R4");
    step(1);
    wr(2'd3, 8'h00);

    // register port
    wr(2'd1, 8'h00); wr(2'd2, 8'h01);
    expect_at(0, 4, 16'h0100, "R2");
    wr(2'd0, 8'h08);
    expect_at(0, 5, 16'h0008, "R2");
    step(1);

    // compare set / clear
    match_at(16'h0100);
    expect_at(1, 0, 1, "R6"); expect_at(1, 1, 1, "R6");
    step(3);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h09);
    match_at(16'h0100);
    expect_at(1, 0, 0, "R6"); expect_at(1, 1, 1, "R6");
    step(3);
    wr(2'd3, 8'h00);

    // toggle, once per match
    wr(2'd0, 8'h02);
    match_at(16'h0100);
    expect_at(1, 0, 1, "R7");
    step(5);
    expect_at(0, 0, 1, "R7");
    match_at(16'h0100);
    expect_at(1, 0, 0, "R7");
    step(3);
    expect_at(0, 1, 1, "R9");
    step(1);
    wr(2'd3, 8'h00);

    // flag only, then special event
    wr(2'd0, 8'h0A);
    match_at(16'h0100);
    expect_at(1, 1, 1, "R8"); expect_at(1, 0, 0, "R8");
    step(3);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h0B);
    match_at(16'h0100);
    expect_at(1, 2, 1, "R8"); expect_at(1, 3, 1, "R8");
    expect_at(1, 1, 1, "R8"); expect_at(1, 0, 0, "R8");
    expect_at(2, 2, 0, "R8"); expect_at(2, 3, 0, "R8");
    step(4);
    wr(2'd3, 8'h00);

    // reserved code behaves as off
    wr(2'd0, 8'h08);
    match_at(16'h0100);
    step(3);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h03);
    expect_at(1, 0, 0, "R1");
    match_at(16'h0100);
    expect_at(1, 1, 0, "R1"); expect_at(1, 0, 0, "R1");
    step(3);

    // PWM: duty = {0x40, 01} = 257
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h1C);
    tmr_cnt = 16'd0;   expect_at(1, 0, 1, "R10"); step(2);
    tmr_cnt = 16'd256; expect_at(1, 0, 1, "R10"); step(2);
    tmr_cnt = 16'd257; expect_at(1, 0, 0, "R10"); step(2);
    wr(2'd1, 8'h10);   // new duty 65, waits for rollover
    tmr_cnt = 16'd100; expect_at(1, 0, 1, "R11"); step(2);
    tmr_cnt = 16'd0;   expect_at(1, 0, 1, "R11"); step(2);
    tmr_cnt = 16'd100; expect_at(1, 0, 0, "R11"); step(2);
    tmr_cnt = 16'd64;  expect_at(1, 0, 1, "R10"); step(2);
    tmr_cnt = 16'hFC41; expect_at(1, 0, 0, "R10"); step(2);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h0C);
    tmr_cnt = 16'd0;   expect_at(1, 0, 0, "R11"); step(2);
    tmr_cnt = 16'd5;   expect_at(1, 0, 0, "R11"); step(2);

    step(6);
    done = 1'b1;
    report();
  end

endmodule